// File: doc/BRIEF.md
# Prescaled Down-Counting Timer

This block is a general-purpose interval timer for a processor's register bus. Software sets a 32-bit prescale value and a 32-bit initial count, then starts the timer from a control register. The count then steps down once every prescale period, from the initial value down to one, after which the timer expires and goes idle. With a 24 MHz clock, a prescale value of 24_000_000 gives one count step per second, so intervals of minutes, hours or days fit in the counter.

A status register tells software whether the timer is still running. Software polls it until it reads zero. A separate control bit stops the timer at any time. Setup registers are locked while the timer runs. On expiry or stop the count reloads the initial value, so a restart repeats the same interval.

The bus is a plain select/write/address/data interface. A read returns its data on `rdata` one clock after the read is presented. Register word addresses are CTRL=0, STATUS=1, PRESCALE=2, INIT=3 and COUNT=4.

Top module: `prescaled_timer`

## Requirements
- R1: After reset, STATUS (address 1) reads 0, PRESCALE (address 2) reads 1, INIT (address 3) reads 0 and COUNT (address 4) reads 0.
- R2: While the timer is idle, a write to PRESCALE or INIT is read back unchanged from the same address. A write to INIT also sets COUNT to the written value.
- R3: A write to CTRL (address 0) with bit 0 set and bit 1 clear, made while idle, makes STATUS bit 0 read 1 from the next cycle on.
- R4: With prescale P ≥ 1 and initial value N ≥ 1, STATUS bit 0 reads 1 for exactly N·P cycles after the start write and reads 0 afterwards.
- R5: While running, COUNT reads N − floor(m/P) in the m-th cycle after the start write. It holds between steps and steps down by exactly one.
- R6: On expiry, COUNT reloads the INIT value, and a second start repeats the same interval.
- R7: A write to CTRL with bit 1 set stops a running timer. STATUS reads 0 from the next cycle, and COUNT reloads the INIT value.
- R8: When bits 0 and 1 are both set in one CTRL write, the stop wins. An idle timer stays idle, and a running timer stops.
- R9: Writes to PRESCALE and INIT while the timer is running are ignored. Their read-back values and the running interval are unchanged.
- R10: A PRESCALE value of 0 behaves as 1, giving one step per cycle, and reads back as 0.
- R11: An INIT value of 0 expires at the first step, after P cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Bus access strobe for this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after a read |

## Verification
The bench reads COUNT on every cycle of a run with prescale 3. A design with an off-by-one in the prescale compare, or one that counts down to zero instead of one, shows the wrong value on the very first step or at the boundary between the last two reads of STATUS. Further runs write PRESCALE and INIT while the timer runs, issue start and stop in one write, use a prescale of 0 and an initial value of 0. A design that let setup writes through would report a changed read-back or a longer interval. One where start beat stop would stay running. A zero prescale taken literally would wrap the prescale counter and never expire within the checked window.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int REG_CTRL     = 0;
  localparam int REG_STATUS   = 1;
  localparam int REG_PRESCALE = 2;
  localparam int REG_INIT     = 3;
  localparam int REG_COUNT    = 4;

  localparam int CTRL_START_BIT = 0;
  localparam int CTRL_STOP_BIT  = 1;

  typedef struct packed {
    logic wrPre;    // load prescale register
    logic wrInit;   // load initial value and count
    logic restart;  // clear prescale counter on start
    logic run;      // timer is active this cycle
    logic dec;      // step the count down
    logic reload;   // copy initial value into count
  } tmrCtl_t;
endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tickNow,
  input  logic              lastTick,
  output tmrCtl_t           ctl,
  output logic              running
);
  logic wrStrobe;
  logic startReq;
  logic stopReq;
  logic expireNow;

  assign wrStrobe  = sel && we;
  assign startReq  = wrStrobe && (addr == ADDR_W'(REG_CTRL)) && wdata[CTRL_START_BIT];
  assign stopReq   = wrStrobe && (addr == ADDR_W'(REG_CTRL)) && wdata[CTRL_STOP_BIT];
  assign expireNow = running && tickNow && lastTick;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
    end else if (stopReq) begin
      running <= 1'b0;
    end else if (!running && startReq) begin
      running <= 1'b1;
    end else if (expireNow) begin
      running <= 1'b0;
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.wrPre   = wrStrobe && !running && (addr == ADDR_W'(REG_PRESCALE));
    ctl.wrInit  = wrStrobe && !running && (addr == ADDR_W'(REG_INIT));
    ctl.restart = !running && startReq && !stopReq;
    ctl.run     = running;
    ctl.dec     = running && tickNow && !lastTick && !stopReq;
    ctl.reload  = (running && stopReq) || expireNow;
  end

  // R7
  stop_halts_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |=> !running);

  // R8
  start_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && stopReq && !running) |=> !running);

  // R4
  expire_chk: assert property (@(posedge clk) disable iff (!rstN)
    expireNow |=> !running);

  // R3
  start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !stopReq && !running) |=> running);
endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int PRE_W  = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  tmrCtl_t           ctl,
  input  logic              running,
  output logic              tickNow,
  output logic              lastTick,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [PRE_W-1:0] PRE_ONE = PRE_W'(1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [PRE_W-1:0]  prescale;
  logic [PRE_W-1:0]  effPre;
  logic [PRE_W-1:0]  preCnt;
  logic [CNT_W-1:0]  initVal;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] readMux;

  assign effPre   = (prescale == '0) ? PRE_ONE : prescale;
  assign tickNow  = (preCnt >= (effPre - PRE_ONE));
  assign lastTick = (count <= CNT_ONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prescale <= PRE_ONE;
      initVal  <= '0;
    end else begin
      if (ctl.wrPre)  prescale <= wdata[PRE_W-1:0];
      if (ctl.wrInit) initVal  <= wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (ctl.restart) begin
      preCnt <= '0;
    end else if (ctl.run) begin
      preCnt <= tickNow ? '0 : preCnt + PRE_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (ctl.wrInit) begin
      count <= wdata[CNT_W-1:0];
    end else if (ctl.reload) begin
      count <= initVal;
    end else if (ctl.dec) begin
      count <= count - CNT_ONE;
    end
  end

  always_comb begin
    unique case (int'(addr))
      REG_STATUS:   readMux = DATA_W'(running);
      REG_PRESCALE: readMux = DATA_W'(prescale);
      REG_INIT:     readMux = DATA_W'(initVal);
      REG_COUNT:    readMux = DATA_W'(count);
      default:      readMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdata <= '0;
    end else if (sel && !we) begin
      rdata <= readMux;
    end
  end

  // R9
  pre_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.run |=> $stable(prescale));

  // R9
  init_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.run |=> $stable(initVal));

  // R5
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.run && !tickNow && !ctl.reload) |=> $stable(count));

  // R10
  pre_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.run |-> (preCnt < effPre));
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import timer_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int PRE_W  = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  tmrCtl_t ctl;
  logic    running;
  logic    tickNow;
  logic    lastTick;

  timer_ctrl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sel      (sel),
    .we       (we),
    .addr     (addr),
    .wdata    (wdata),
    .tickNow  (tickNow),
    .lastTick (lastTick),
    .ctl      (ctl),
    .running  (running)
  );

  timer_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .PRE_W  (PRE_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .sel      (sel),
    .we       (we),
    .addr     (addr),
    .wdata    (wdata),
    .ctl      (ctl),
    .running  (running),
    .tickNow  (tickNow),
    .lastTick (lastTick),
    .rdata    (rdata)
  );
endmodule

// File: tb/prescaled_timer_bench.sv
`timescale 1ns/1ps
module prescaled_timer_bench;
  localparam int A_CTRL = 0, A_STAT = 1, A_PRE = 2, A_INIT = 3, A_CNT = 4;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sel = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  expItem_t scoreQ[$];
  logic     rdIssued = 1'b0;
  int       nChecks = 0;
  int       nFails = 0;
  bit       done = 1'b0;

  prescaled_timer u_prescaled_timer (
    .clk   (clk),
    .rstN  (rstN),
    .sel   (sel),
    .we    (we),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata)
  );

  always #2.5 clk = ~clk;

  // monitor: note which cycles carried a read, compare half a cycle later
  always @(posedge clk) rdIssued <= sel && !we;

  always @(negedge clk) begin
    if (rdIssued) begin
      expItem_t it;
      it = scoreQ.pop_front();
      nChecks++;
      if (rdata !== it.exp) begin
        nFails++;
        $display("FAIL %s: got %0d expected %0d", it.tag, rdata, it.exp);
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    sel = 1'b1; we = 1'b1; addr = 3'(a); wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string tag);
    expItem_t it;
    it.exp = e; it.tag = tag;
    scoreQ.push_back(it);
    sel = 1'b1; we = 1'b0; addr = 3'(a);
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(A_STAT, 0, "R1 status");
    rd(A_PRE,  1, "R1 prescale");
    rd(A_INIT, 0, "R1 init");
    rd(A_CNT,  0, "R1 count");

    // R2 readback while idle
    wr(A_PRE, 3);
    wr(A_INIT, 4);
    rd(A_PRE,  3, "R2 prescale");
    rd(A_INIT, 4, "R2 init");
    rd(A_CNT,  4, "R2 count");

    // R3/R5 stepping with P=3, N=4: read COUNT every cycle
    wr(A_CTRL, 1);
    rd(A_STAT, 1, "R3 status after start");
    for (int m = 1; m < 12; m++) rd(A_CNT, 32'(4 - m / 3), "R5 count step");
    rd(A_STAT, 0, "R4 expired at N*P");
    rd(A_CNT,  4, "R6 count reloaded");

    // R6/R4 repeat interval
    wr(A_CTRL, 1);
    idle(11);
    rd(A_STAT, 1, "R4 running at N*P-1");
    rd(A_STAT, 0, "R6 repeat expired at N*P");

    // R9 setup writes ignored while running (P=2, N=3)
    wr(A_PRE, 2);
    wr(A_INIT, 3);
    wr(A_CTRL, 1);
    wr(A_PRE, 7);
    wr(A_INIT, 9);
    rd(A_PRE,  2, "R9 prescale locked");
    rd(A_INIT, 3, "R9 init locked");
    idle(1);
    rd(A_STAT, 1, "R9 interval m=5");
    rd(A_STAT, 0, "R9 interval unchanged m=6");

    // R7 stop mid-run (P=1, N=10)
    wr(A_PRE, 1);
    wr(A_INIT, 10);
    wr(A_CTRL, 1);
    idle(3);
    wr(A_CTRL, 2);
    rd(A_STAT, 0, "R7 stopped");
    rd(A_CNT, 10, "R7 count reloaded");

    // R8 start and stop together
    wr(A_CTRL, 3);
    rd(A_STAT, 0, "R8 idle stays idle");
    wr(A_CTRL, 1);
    wr(A_CTRL, 3);
    rd(A_STAT, 0, "R8 running stops");

    // R10 prescale zero acts as one (N=3)
    wr(A_PRE, 0);
    wr(A_INIT, 3);
    rd(A_PRE, 0, "R10 prescale reads 0");
    wr(A_CTRL, 1);
    idle(2);
    rd(A_STAT, 1, "R10 running m=2");
    rd(A_STAT, 0, "R10 expired m=3");

    // R11 init zero expires after one prescale period (P=2)
    wr(A_PRE, 2);
    wr(A_INIT, 0);
    wr(A_CTRL, 1);
    rd(A_STAT, 1, "R11 running m=0");
    rd(A_STAT, 1, "R11 running m=1");
    rd(A_STAT, 0, "R11 expired m=2");

    idle(3);
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule